// File: doc/BRIEF.md
# Memory Protection Entry Configuration Registers

This block is the register store behind a set of physical memory protection entries. Each entry owns an 8-bit configuration byte and an address register. A small security register holds three global flags: lockdown, a machine-mode whitelist policy and a rule-lock bypass. Software reaches these registers through a CSR port that carries a space select, an index, write data and a write enable. Reads are combinational from the same port. All configuration bytes and addresses are also presented in parallel to the region-matching logic downstream.

A configuration CSR packs `XLEN/8` entry bytes. Each byte of a write is screened on its own against its entry's lock state and the security flags. A refused byte leaves that entry unchanged, while the other bytes of the same CSR may still land. Address writes are refused for an entry that is locked. They are also refused for the entry below a locked top-of-range entry, because that address is the lower bound of the locked region. Every configuration CSR write produces a one-cycle flush strobe, so cached permission lookups can be discarded.

An enhanced-mode strap selects between plain lock semantics and the lockdown/bypass rule set. The strap is meant to be tied off or held static.

Top module: `pmp_regfile`

## Requirements
- R1: While reset is asserted, all configuration bytes, all address registers and the security register read as zero, and the flush strobe is low.
- R2: A configuration CSR write with index n places byte b of the write data (bits 8b+7:8b) into entry n*XLEN/8+b. A configuration CSR read assembles the bytes in the same order. A configuration byte holds R at bit 0, W at bit 1, X at bit 2, the match mode at bits 4:3 (01 is top-of-range) and the lock flag at bit 7. An accepted byte is stored unchanged and appears on the entry outputs after the next clock edge.
- R3: With the enhanced strap low, a configuration byte write to an entry whose lock flag is set is dropped, and unlocked entries in the same CSR are still updated.
- R4: With the enhanced strap high, a configuration byte write is accepted whenever the bypass flag is set. With bypass clear and lockdown clear, it is accepted only if the entry is unlocked.
- R5: With the enhanced strap high, bypass clear and lockdown set, a byte is accepted exactly when it sets lock with X clear, or leaves lock clear with bits 2:0 other than 3'b110. This holds whatever the entry's current lock state.
- R6: An address register write to a locked entry is dropped.
- R7: An address register write to entry k is dropped when entry k+1 is locked and in top-of-range mode. The last entry has no such neighbour.
- R8: The security register holds lockdown at bit 0, whitelist at bit 1 and bypass at bit 2. Once set, lockdown and whitelist cannot be cleared by a write.
- R9: A security register write cannot set bypass while bypass is currently clear and any entry is locked.
- R10: Configuration or address accesses to entries beyond the implemented count are ignored, and reads of them return zero. The reserved space (3) ignores writes and reads as zero.
- R11: The flush strobe is high for exactly the one cycle after each configuration CSR write, including writes to out-of-range indices, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode_i | input | 1 | Static strap selecting the lockdown/bypass rule set |
| csr_we_i | input | 1 | CSR write enable |
| csr_space_i | input | 2 | 0 configuration, 1 address, 2 security, 3 reserved |
| csr_idx_i | input | IDX_W | CSR index within the space |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data for the current space and index |
| entry_cfg_o | output | 8*N_ENTRIES | All configuration bytes, entry e at bits 8e+7:8e |
| entry_addr_o | output | XLEN*N_ENTRIES | All address registers, entry e at bits XLEN*e+XLEN-1:XLEN*e |
| sec_cfg_o | output | 3 | Security flags: bypass, whitelist, lockdown |
| flush_o | output | 1 | One-cycle strobe after a configuration CSR write |

## Verification
Several rules are checked by assertions on every cycle:
- Locked configuration bytes and addresses hold their value.
- Byte values that lockdown forbids are refused.
- A write under bypass is accepted.
- Lockdown and whitelist never fall once set.
- Bypass cannot rise while an entry is locked.
- Out-of-range addresses read as zero, and the flush strobe tracks configuration writes.

The bench scenarios cover what the assertions do not. They show that lockdown still admits the allowed byte shapes. They sweep all 256 byte values under every combination of strap, bypass, lockdown and prior lock. They show that one refused byte leaves its CSR neighbours written, that the byte-to-entry mapping and readback order are correct, and that the top-of-range guard spares the last entry.

// File: rtl/pmp_regfile_pkg.sv
package pmp_regfile_pkg;

  localparam int unsigned CFG_BIT_R    = 0;
  localparam int unsigned CFG_BIT_W    = 1;
  localparam int unsigned CFG_BIT_X    = 2;
  localparam int unsigned CFG_MODE_LO  = 3;
  localparam int unsigned CFG_MODE_HI  = 4;
  localparam int unsigned CFG_BIT_LOCK = 7;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_NA4   = 2'b10,
    MODE_NAPOT = 2'b11
  } match_mode_e;

  typedef enum logic [1:0] {
    SPACE_CFG  = 2'd0,
    SPACE_ADDR = 2'd1,
    SPACE_SEC  = 2'd2,
    SPACE_NONE = 2'd3
  } csr_space_e;

  // packed so that lockdown is bit 0, whitelist bit 1, bypass bit 2
  typedef struct packed {
    logic bypass;
    logic whitelist;
    logic lockdown;
  } sec_cfg_t;

  // acceptance rule for one configuration byte
  function automatic logic cfg_write_ok(input logic enh, input sec_cfg_t sec,
                                        input logic cur_lock, input logic [7:0] nv);
    logic lock_new;
    logic x_new;
    logic wx_only;
    lock_new = nv[CFG_BIT_LOCK];
    x_new    = nv[CFG_BIT_X];
    wx_only  = (nv[CFG_BIT_X:CFG_BIT_R] == 3'b110);
    if (!enh) begin
      return !cur_lock;
    end
    return sec.bypass
         | (!sec.lockdown & !cur_lock)
         | (sec.lockdown & ((lock_new & !x_new) | (!lock_new & !wx_only)));
  endfunction

  function automatic logic is_tor_locked(input logic [7:0] cfg);
    return cfg[CFG_BIT_LOCK] &&
           (match_mode_e'(cfg[CFG_MODE_HI:CFG_MODE_LO]) == MODE_TOR);
  endfunction

endpackage

// File: rtl/pmp_regfile_entry.sv
module pmp_regfile_entry
  import pmp_regfile_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enh_i,
  input  sec_cfg_t        sec_i,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wbyte_i,
  input  logic            addr_we_i,
  input  logic [XLEN-1:0] addr_wdata_i,
  input  logic            next_tor_lock_i,
  output logic [7:0]      cfg_q_o,
  output logic [XLEN-1:0] addr_q_o
);

  logic [7:0]      cfg_q;
  logic [XLEN-1:0] addr_q;
  logic            cfg_en;
  logic            addr_en;

  always_comb begin
    cfg_en  = cfg_we_i && cfg_write_ok(enh_i, sec_i, cfg_q[CFG_BIT_LOCK], cfg_wbyte_i);
    addr_en = addr_we_i && !cfg_q[CFG_BIT_LOCK] && !next_tor_lock_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_wbyte_i;
      if (addr_en) addr_q <= addr_wdata_i;
    end
  end

  assign cfg_q_o  = cfg_q;
  assign addr_q_o = addr_q;

  // R3: plain mode keeps a locked byte
  a_r3_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !enh_i && cfg_q[CFG_BIT_LOCK]) |=> $stable(cfg_q));

  // R4: bypass admits any byte
  a_r4_bypass_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && enh_i && sec_i.bypass) |=> (cfg_q == $past(cfg_wbyte_i)));

  // R5: lockdown refuses an unlocked W+X shape
  a_r5_lockdown_refuses_wx: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && enh_i && !sec_i.bypass && sec_i.lockdown &&
     !cfg_wbyte_i[CFG_BIT_LOCK] && (cfg_wbyte_i[2:0] == 3'b110)) |=> $stable(cfg_q));

  // R5: lockdown refuses a locked byte with X set
  a_r5_lockdown_refuses_lx: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && enh_i && !sec_i.bypass && sec_i.lockdown &&
     cfg_wbyte_i[CFG_BIT_LOCK] && cfg_wbyte_i[CFG_BIT_X]) |=> $stable(cfg_q));

  // R6: locked entry keeps its address
  a_r6_locked_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we_i && cfg_q[CFG_BIT_LOCK]) |=> $stable(addr_q));

  // R7: locked top-of-range neighbour guards this address
  a_r7_tor_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we_i && next_tor_lock_i) |=> $stable(addr_q));

endmodule

// File: rtl/pmp_regfile_sec.sv
module pmp_regfile_sec
  import pmp_regfile_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we_i,
  input  logic [2:0] wdata_i,
  input  logic     any_locked_i,
  output sec_cfg_t sec_o
);

  sec_cfg_t sec_q;
  sec_cfg_t sec_d;

  always_comb begin
    sec_d = sec_cfg_t'(wdata_i);
    if (!sec_q.bypass && any_locked_i) sec_d.bypass = 1'b0;
    sec_d.lockdown  = sec_d.lockdown  | sec_q.lockdown;
    sec_d.whitelist = sec_d.whitelist | sec_q.whitelist;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (we_i) begin
      sec_q <= sec_d;
    end
  end

  assign sec_o = sec_q;

  a_r8_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.lockdown |=> sec_q.lockdown);

  a_r8_whitelist_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.whitelist |=> sec_q.whitelist);

  a_r9_bypass_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !sec_q.bypass && any_locked_i) |=> !sec_q.bypass);

endmodule

// File: rtl/pmp_regfile_rdmux.sv
module pmp_regfile_rdmux
  import pmp_regfile_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 4
) (
  input  csr_space_e      space_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]      cfg_i  [N_ENTRIES],
  input  logic [XLEN-1:0] addr_i [N_ENTRIES],
  input  sec_cfg_t        sec_i,
  output logic [XLEN-1:0] rdata_o
);

  localparam int unsigned BPC   = XLEN / 8;
  localparam int unsigned SEL_W = $clog2(N_ENTRIES);

  always_comb begin
    int unsigned ent;
    rdata_o = '0;
    ent     = 0;
    unique case (space_i)
      SPACE_CFG: begin
        for (int unsigned b = 0; b < BPC; b++) begin
          ent = BPC * {{(32-IDX_W){1'b0}}, idx_i} + b;
          if (ent < N_ENTRIES) rdata_o[b*8 +: 8] = cfg_i[ent[SEL_W-1:0]];
        end
      end
      SPACE_ADDR: begin
        if ({{(32-IDX_W){1'b0}}, idx_i} < N_ENTRIES) rdata_o = addr_i[idx_i[SEL_W-1:0]];
      end
      SPACE_SEC: begin
        rdata_o[2:0] = sec_i;
      end
      default: rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_regfile_pkg::*;
#(
  parameter  int unsigned N_ENTRIES = 8,
  parameter  int unsigned XLEN      = 32,
  localparam int unsigned IDX_W     = $clog2(N_ENTRIES) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enh_mode_i,
  input  logic                      csr_we_i,
  input  logic [1:0]                csr_space_i,
  input  logic [IDX_W-1:0]          csr_idx_i,
  input  logic [XLEN-1:0]           csr_wdata_i,
  output logic [XLEN-1:0]           csr_rdata_o,
  output logic [8*N_ENTRIES-1:0]    entry_cfg_o,
  output logic [XLEN*N_ENTRIES-1:0] entry_addr_o,
  output logic [2:0]                sec_cfg_o,
  output logic                      flush_o
);

  localparam int unsigned BPC      = XLEN / 8;
  localparam int unsigned CFG_CSRS = (N_ENTRIES + BPC - 1) / BPC;

  csr_space_e      space;
  sec_cfg_t        sec;
  logic [7:0]      cfg_q  [N_ENTRIES];
  logic [XLEN-1:0] addr_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] cfg_we;
  logic [N_ENTRIES-1:0] addr_we;
  logic [N_ENTRIES-1:0] next_tor;
  logic [N_ENTRIES-1:0] lock_vec;
  logic            any_locked;
  logic            sec_we;
  logic            cfg_space_we;
  logic            flush_q;

  assign space        = csr_space_e'(csr_space_i);
  assign cfg_space_we = csr_we_i && (space == SPACE_CFG);
  assign sec_we       = csr_we_i && (space == SPACE_SEC);
  assign any_locked   = |lock_vec;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    assign cfg_we[e]   = cfg_space_we && (csr_idx_i == IDX_W'(e / BPC));
    assign addr_we[e]  = csr_we_i && (space == SPACE_ADDR) && (csr_idx_i == IDX_W'(e));
    assign lock_vec[e] = cfg_q[e][CFG_BIT_LOCK];

    if (e + 1 < N_ENTRIES) begin : g_next
      assign next_tor[e] = is_tor_locked(cfg_q[e+1]);
    end else begin : g_last
      assign next_tor[e] = 1'b0;
    end

    pmp_regfile_entry #(.XLEN(XLEN)) u_entry (
      .clk             (clk),
      .rst_n           (rst_n),
      .enh_i           (enh_mode_i),
      .sec_i           (sec),
      .cfg_we_i        (cfg_we[e]),
      .cfg_wbyte_i     (csr_wdata_i[(e % BPC)*8 +: 8]),
      .addr_we_i       (addr_we[e]),
      .addr_wdata_i    (csr_wdata_i),
      .next_tor_lock_i (next_tor[e]),
      .cfg_q_o         (cfg_q[e]),
      .addr_q_o        (addr_q[e])
    );

    assign entry_cfg_o[e*8 +: 8]        = cfg_q[e];
    assign entry_addr_o[e*XLEN +: XLEN] = addr_q[e];
  end

  pmp_regfile_sec u_sec (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (sec_we),
    .wdata_i      (csr_wdata_i[2:0]),
    .any_locked_i (any_locked),
    .sec_o        (sec)
  );

  pmp_regfile_rdmux #(
    .N_ENTRIES (N_ENTRIES),
    .XLEN      (XLEN),
    .IDX_W     (IDX_W)
  ) u_rdmux (
    .space_i (space),
    .idx_i   (csr_idx_i),
    .cfg_i   (cfg_q),
    .addr_i  (addr_q),
    .sec_i   (sec),
    .rdata_o (csr_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= cfg_space_we;
    end
  end

  assign flush_o   = flush_q;
  assign sec_cfg_o = sec;

  a_r11_flush_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_space_i == 2'd0) |=> flush_o);

  a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we_i && csr_space_i == 2'd0) |=> !flush_o);

  a_r10_oob_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_space_i == 2'd0 && csr_idx_i >= IDX_W'(CFG_CSRS)) |=> $stable(entry_cfg_o));

  a_r10_oob_addr_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_space_i == 2'd1 && csr_idx_i >= IDX_W'(N_ENTRIES)) |-> (csr_rdata_o == '0));

  a_r10_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_space_i == 2'd3) |-> (csr_rdata_o == '0));

endmodule

// File: tb/tb_pmp_regfile.sv
`timescale 1ns/1ps
module tb_pmp_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enh_mode;
  logic        csr_we;
  logic [1:0]  csr_space;
  logic [3:0]  csr_idx;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic [63:0] entry_cfg;
  logic [255:0] entry_addr;
  logic [2:0]  sec_cfg;
  logic        flush;

  always #2 clk = ~clk;

  pmp_regfile #(.N_ENTRIES(8), .XLEN(32)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enh_mode_i   (enh_mode),
    .csr_we_i     (csr_we),
    .csr_space_i  (csr_space),
    .csr_idx_i    (csr_idx),
    .csr_wdata_i  (csr_wdata),
    .csr_rdata_o  (csr_rdata),
    .entry_cfg_o  (entry_cfg),
    .entry_addr_o (entry_addr),
    .sec_cfg_o    (sec_cfg),
    .flush_o      (flush)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0]  m_cfg  [8];
  logic [31:0] m_addr [8];
  logic [2:0]  m_sec;
  logic        m_enh;
  logic [31:0] rng = 32'h1234_5679;

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic byte_allowed(input logic [7:0] old, input logic [7:0] nv);
    if (!m_enh) return !old[7];
    if (m_sec[2]) return 1'b1;
    if (!m_sec[0]) return !old[7];
    if (nv[7]) return !nv[2];
    return nv[2:0] != 3'b110;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] sp, input logic [3:0] idx);
    logic [31:0] r;
    int e;
    r = '0;
    case (sp)
      2'd0: for (int i = 0; i < 4; i++) begin
        e = int'(idx) * 4 + i;
        if (e < 8) r[i*8 +: 8] = m_cfg[e];
      end
      2'd1: if (idx < 8) r = m_addr[idx[2:0]];
      2'd2: r = {29'b0, m_sec};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic exp_flush, input logic [1:0] sp,
                           input logic [3:0] idx);
    logic [63:0]  ec;
    logic [255:0] ea;
    for (int e = 0; e < 8; e++) begin
      ec[e*8 +: 8]   = m_cfg[e];
      ea[e*32 +: 32] = m_addr[e];
    end
    chk(tag, "entry_cfg", {192'b0, entry_cfg}, {192'b0, ec});
    chk(tag, "entry_addr", entry_addr, ea);
    chk(tag, "sec_cfg", {253'b0, sec_cfg}, {253'b0, m_sec});
    chk("R11", "flush", {255'b0, flush}, {255'b0, exp_flush});
    chk((sp == 2'd0) ? "R2" : tag, "rdata", {224'b0, csr_rdata}, {224'b0, model_read(sp, idx)});
  endtask

  task automatic do_reset(input logic enh);
    @(negedge clk);
    rst_n = 1'b0; enh_mode = enh; csr_we = 1'b0;
    csr_space = 2'd0; csr_idx = '0; csr_wdata = '0;
    m_enh = enh; m_sec = '0;
    for (int e = 0; e < 8; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    @(negedge clk);
    check_all("R1", 1'b0, 2'd0, 4'd0);
    rst_n = 1'b1;
  endtask

  task automatic apply(input logic [1:0] sp, input logic [3:0] idx, input logic [31:0] wd);
    string tag;
    logic [7:0] pre [8];
    logic anylk;
    logic nt;
    logic [2:0] ns;
    int e;
    anylk = 1'b0;
    for (int i = 0; i < 8; i++) begin pre[i] = m_cfg[i]; anylk |= m_cfg[i][7]; end
    case (sp)
      2'd0: begin
        if (idx >= 2) tag = "R10";
        else if (!m_enh) tag = "R3";
        else if (m_sec[2] || !m_sec[0]) tag = "R4";
        else tag = "R5";
        for (int i = 0; i < 4; i++) begin
          e = int'(idx) * 4 + i;
          if (e < 8 && byte_allowed(pre[e], wd[i*8 +: 8])) m_cfg[e] = wd[i*8 +: 8];
        end
      end
      2'd1: begin
        if (idx >= 8) tag = "R10";
        else begin
          nt = 1'b0;
          if (idx < 7) nt = pre[idx+1][7] && (pre[idx+1][4:3] == 2'b01);
          tag = nt ? "R7" : "R6";
          if (!pre[idx[2:0]][7] && !nt) m_addr[idx[2:0]] = wd;
        end
      end
      2'd2: begin
        tag = (!m_sec[2] && anylk && wd[2]) ? "R9" : "R8";
        ns = wd[2:0];
        if (!m_sec[2] && anylk) ns[2] = 1'b0;
        ns[0] = ns[0] | m_sec[0];
        ns[1] = ns[1] | m_sec[1];
        m_sec = ns;
      end
      default: tag = "R10";
    endcase
    @(negedge clk);
    csr_we = 1'b1; csr_space = sp; csr_idx = idx; csr_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
    #0.5;
    check_all(tag, sp == 2'd0, sp, idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enh_mode = 1'b0; csr_we = 1'b0;
    csr_space = 2'd0; csr_idx = '0; csr_wdata = '0;

    // R3 R4 R5: every byte value under every flag and prior-lock combination
    for (int en = 0; en < 2; en++)
      for (int rb = 0; rb < 2; rb++)
        for (int md = 0; md < 2; md++)
          for (int lk = 0; lk < 2; lk++)
            for (int v = 0; v < 256; v++) begin
              do_reset(en[0]);
              if (rb != 0) apply(2'd2, 4'd0, 32'h4);
              if (lk != 0) apply(2'd0, 4'd0, 32'h0000_0080);
              if (md != 0) apply(2'd2, 4'd0, {29'b0, rb[0], 2'b01});
              apply(2'd0, 4'd0, {8'h11, 8'h96, 8'h3c, v[7:0]});
            end

    // R6 R7: odd entries locked with each match mode, every address index
    for (int a = 0; a < 4; a++)
      for (int lk = 0; lk < 2; lk++) begin
        logic [7:0] pat;
        do_reset(1'b0);
        pat = {lk[0], 2'b00, a[1:0], 3'b011};
        apply(2'd0, 4'd0, {pat, 8'h07, pat, 8'h05});
        apply(2'd0, 4'd1, {pat, 8'h01, pat, 8'h03});
        for (int i = 0; i < 16; i++) apply(2'd1, i[3:0], 32'hA500_0000 | i);
      end

    // R8 R9 R10 R11 R2: mixed operation stream with periodic resets
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] d;
      if (n % 40 == 0) begin
        rng = step(rng);
        do_reset(rng[0]);
      end
      rng = step(rng);
      d = step(rng ^ 32'h5bd1_e995);
      case (rng[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: begin
          if (rng[5:4] != 2'b11) d = d & 32'h7f7f_7f7f;
          apply(2'd0, {2'b00, (rng[9:8] == 2'b11) ? 2'b10 : rng[9:8] & 2'b01}, d);
        end
        3'd4, 3'd5: apply(2'd1, rng[11:8], d);
        3'd6: apply(2'd2, 4'd0, (rng[13:12] == 2'b00) ? d : (d & 32'hfffffffc));
        default: apply(2'd3, rng[11:8], d);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule